// File: doc/BRIEF.md
# PCI-to-ISA Cycle Splitting Bridge

This block sits on the target side of a fast PCI-style bus. It serves slow 8-bit or 16-bit ISA-style devices. Each request is a single data phase: a dword address, four active-low byte enables, a read/write command and a space select (memory or I/O). The bridge converts it into a series of narrow ISA cycles. It emits one sub-cycle per enabled byte (8-bit port) or per enabled word (16-bit port), in ascending address order. Read data from the sub-cycles is collected into a 32-bit holding register and returned with a single TRDY pulse.

The ISA side is paced by a clock-enable strobe from the fast clock domain. Each sub-cycle has three parts in order: an address-latch pulse, a command strobe held for a parameterised number of ISA clocks, and one idle ISA clock before the next sub-cycle. The 24-bit ISA address is presented on one merged address bus.

The bridge can also run in delayed mode. There it answers the first attempt with a retry (STOP) and keeps the request. It runs the ISA cycles in the background and completes only when the master repeats the identical request after the data is ready. Meanwhile the PCI bus is free for other traffic.

Top module: `pisa_bridge`

## Requirements
- R1: After reset, trdy, stop, bale and sd_oe are low and all four command strobes (ior_n, iow_n, memr_n, memw_n) are high.
- R2: With port16 low, each byte lane i (0..3) whose req_be_n[i] is 0 produces one sub-cycle with sa = {req_dw_addr, 2'b00} + i. Sub-cycles run in ascending lane order.
- R3: With port16 high, word j (0..1) produces one sub-cycle with sa = {req_dw_addr, 2'b00} + 2*j when req_be_n[2j] or req_be_n[2j+1] is 0. Word 0 runs before word 1.
- R4: Each sub-cycle pulls exactly one command strobe low: ior_n for an I/O read, iow_n for an I/O write, memr_n for a memory read, memw_n for a memory write (req_io = 1 selects I/O space, req_write = 1 selects write). No two strobes are ever low together.
- R5: bale is high for exactly one ISA clock (one isa_ce period). The command strobe falls on the edge where bale falls and stays low for STROBE_W ISA clocks. bale and a strobe are never active together, and sa is stable while a strobe is low.
- R6: Between the rising edge of one sub-cycle's strobe and the rising edge of the next sub-cycle's bale within the same transfer there is exactly one ISA clock.
- R7: For a read, rdata (valid with trdy) holds, on each enabled byte lane, the byte read from that lane's address. With port16 low, the byte is taken from sd_in[7:0]. With port16 high, it is taken from sd_in[7:0] for even lanes and from sd_in[15:8] for odd lanes. Disabled lanes read as zero.
- R8: For a write sub-cycle, sd_oe is high while the strobe is low. sd_out carries req_wdata[16j+15:16j] for word j when port16 is high, or {8'h00, req_wdata[8i+7:8i]} for byte i when port16 is low. For read sub-cycles sd_oe stays low.
- R9: With delay_en low, the bridge never asserts stop. It asserts trdy exactly once per request, and only after the last command strobe of that request has returned high.
- R10: With delay_en low, a request with all four byte enables high completes with trdy and produces no bale and no strobe.
- R11: With delay_en high, the first attempt of a request is answered with stop and no trdy, and its ISA sub-cycles run without further attempts.
- R12: With delay_en high, while a request is pending, an attempt whose address, command, space or byte enables differ is answered with stop and leaves the pending sub-cycles unchanged. The identical attempt after the sub-cycles end gets trdy, and a later identical request starts over with stop.
- R13: trdy and stop are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst | input | 1 | Synchronous active-high reset |
| isa_ce | input | 1 | One-cycle enable marking each ISA clock |
| delay_en | input | 1 | 1 = delayed (retry) mode |
| port16 | input | 1 | Target port width: 1 = 16-bit, 0 = 8-bit |
| req_valid | input | 1 | Request held by the master until trdy or stop |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_dw_addr | input | AW-2 | Dword address of the request |
| req_be_n | input | 4 | Active-low byte enables |
| req_wdata | input | 32 | Write data |
| trdy | output | 1 | Completion pulse |
| stop | output | 1 | Retry pulse (delayed mode) |
| rdata | output | 32 | Gathered read data, valid with trdy |
| bale | output | 1 | Address latch enable |
| sa | output | AW | Merged ISA address |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| sd_out | output | 16 | ISA write data |
| sd_oe | output | 1 | ISA data output enable |
| sd_in | input | 16 | ISA read data |

## Verification
The bench goes after sparse byte-enable patterns on both port widths, for example a single odd lane, or a 16-bit access with only one byte of a word enabled. A wrong lane-to-address mapping, skipped lanes or reordered sub-cycles would show up as a wrong address list or as read data in the wrong lane. It checks the all-disabled request, which a careless design would either hang on or turn into a spurious ISA cycle. It checks TRDY placement against the last strobe, which a design that completes early would violate. In delayed mode it sends a mismatched retry during a pending cycle and repeats the same request after completion. A design that overwrote its latched entry would run the wrong sub-cycles; one that failed to clear the entry would hand stale data to the new request instead of retrying it.

// File: rtl/pisa_pkg.sv
package pisa_pkg;

  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ARM,
    SQ_BALE,
    SQ_CMD
  } sq_state_e;

  // Units that need an ISA sub-cycle: bytes on an 8-bit port, words on a 16-bit port.
  function automatic logic [LANES-1:0] unit_mask(input logic [LANES-1:0] be_n,
                                                 input logic w16);
    logic [LANES-1:0] m;
    if (w16) m = {2'b00, ~(be_n[3] & be_n[2]), ~(be_n[1] & be_n[0])};
    else     m = ~be_n;
    return m;
  endfunction

endpackage

// File: rtl/pisa_lane_sel.sv
module pisa_lane_sel #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Lowest pending unit wins: ascending address order.
  always_comb begin
    any = |mask;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/pisa_isa_seq.sv
module pisa_isa_seq
  import pisa_pkg::*;
#(
  parameter int AW       = 24,
  parameter int STROBE_W = 3,
  parameter int CW       = $clog2(STROBE_W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          isa_ce,
  input  logic          start,
  input  logic [AW-1:0] s_addr,
  input  logic          s_write,
  input  logic          s_io,
  input  logic [15:0]   s_wdata,
  input  logic [15:0]   sd_in,
  output logic          busy,
  output logic          bale,
  output logic [AW-1:0] sa,
  output logic          ior_n,
  output logic          iow_n,
  output logic          memr_n,
  output logic          memw_n,
  output logic [15:0]   sd_out,
  output logic          sd_oe,
  output logic          cap_en,
  output logic [15:0]   cap_data
);

  sq_state_e     st;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic          io_q;

  assign busy = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      io_q     <= 1'b0;
      bale     <= 1'b0;
      sa       <= '0;
      ior_n    <= 1'b1;
      iow_n    <= 1'b1;
      memr_n   <= 1'b1;
      memw_n   <= 1'b1;
      sd_out   <= '0;
      sd_oe    <= 1'b0;
      cap_en   <= 1'b0;
      cap_data <= '0;
    end else begin
      cap_en <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          st     <= SQ_ARM;
          sa     <= s_addr;
          wr_q   <= s_write;
          io_q   <= s_io;
          sd_out <= s_wdata;
          sd_oe  <= s_write;
        end
        SQ_ARM: if (isa_ce) begin
          st   <= SQ_BALE;
          bale <= 1'b1;
        end
        SQ_BALE: if (isa_ce) begin
          st     <= SQ_CMD;
          bale   <= 1'b0;
          cnt    <= CW'(STROBE_W - 1);
          ior_n  <= !( io_q && !wr_q);
          iow_n  <= !( io_q &&  wr_q);
          memr_n <= !(!io_q && !wr_q);
          memw_n <= !(!io_q &&  wr_q);
        end
        SQ_CMD: if (isa_ce) begin
          if (cnt == '0) begin
            st       <= SQ_IDLE;
            ior_n    <= 1'b1;
            iow_n    <= 1'b1;
            memr_n   <= 1'b1;
            memw_n   <= 1'b1;
            sd_oe    <= 1'b0;
            cap_en   <= !wr_q;
            cap_data <= sd_in;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({ior_n, iow_n, memr_n, memw_n}) >= 3); // R4

  AST_BALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    bale |-> (ior_n && iow_n && memr_n && memw_n)); // R5

  AST_SA_HELD: assert property (@(posedge clk) disable iff (rst)
    !(ior_n && iow_n && memr_n && memw_n) |-> $stable(sa)); // R5

  AST_OE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!iow_n || !memw_n) |-> sd_oe); // R8

  AST_NO_OE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!ior_n || !memr_n) |-> !sd_oe); // R8

endmodule

// File: rtl/pisa_gather.sv
module pisa_gather #(
  parameter int LANES = 4,
  parameter int DW    = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cap_en,
  input  logic [1:0]       cap_idx,
  input  logic             cap_w16,
  input  logic [LANES-1:0] cap_be_n,
  input  logic [15:0]      cap_data,
  output logic [DW-1:0]    hold
);

  logic [7:0] lane_q [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [1:0] BYTE_ID = 2'(k);
    localparam logic [1:0] WORD_ID = 2'(k / 2);
    localparam int         HALF    = k % 2;

    logic hit;
    assign hit = cap_en && !cap_be_n[k] &&
                 (cap_w16 ? (cap_idx == WORD_ID) : (cap_idx == BYTE_ID));

    always_ff @(posedge clk) begin
      if (rst || clr)  lane_q[k] <= '0;
      else if (hit)    lane_q[k] <= cap_w16 ? cap_data[8*HALF +: 8] : cap_data[7:0];
    end

    assign hold[8*k +: 8] = lane_q[k];
  end

endmodule

// File: rtl/pisa_bridge.sv
module pisa_bridge
  import pisa_pkg::*;
#(
  parameter int AW       = 24,
  parameter int STROBE_W = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          isa_ce,
  input  logic          delay_en,
  input  logic          port16,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [AW-3:0] req_dw_addr,
  input  logic [3:0]    req_be_n,
  input  logic [31:0]   req_wdata,
  output logic          trdy,
  output logic          stop,
  output logic [31:0]   rdata,
  output logic          bale,
  output logic [AW-1:0] sa,
  output logic          ior_n,
  output logic          iow_n,
  output logic          memr_n,
  output logic          memw_n,
  output logic [15:0]   sd_out,
  output logic          sd_oe,
  input  logic [15:0]   sd_in
);

  localparam int IW = $clog2(LANES);

  // Latched request entry
  logic             ent_v, ent_done;
  logic [AW-3:0]    ent_dw;
  logic [3:0]       ent_be_n;
  logic             ent_wr, ent_io, ent_w16;
  logic [31:0]      ent_wdata;
  logic [LANES-1:0] pend;
  logic [IW-1:0]    cur_idx;
  logic             start_r;

  logic             nx_any;
  logic [IW-1:0]    nx_idx;
  logic             seq_busy;
  logic             cap_en;
  logic [15:0]      cap_data;
  logic [DW-1:0]    hold;

  logic             resp_ok, accept_new, match;
  logic [AW-1:0]    sub_addr;
  logic [15:0]      sub_wdata;

  assign resp_ok    = !trdy && !stop;
  assign accept_new = req_valid && resp_ok && !ent_v;
  assign match      = (req_dw_addr == ent_dw) && (req_be_n == ent_be_n) &&
                      (req_write == ent_wr) && (req_io == ent_io);

  assign sub_addr  = {ent_dw, 2'b00} +
                     (ent_w16 ? AW'({cur_idx, 1'b0}) : AW'(cur_idx));
  assign sub_wdata = ent_w16 ? (cur_idx[0] ? ent_wdata[31:16] : ent_wdata[15:0])
                             : {8'h00, ent_wdata[{cur_idx, 3'b000} +: 8]};

  pisa_lane_sel #(.N(LANES), .IW(IW)) u_sel (
    .mask (pend),
    .any  (nx_any),
    .idx  (nx_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trdy      <= 1'b0;
      stop      <= 1'b0;
      rdata     <= '0;
      ent_v     <= 1'b0;
      ent_done  <= 1'b0;
      ent_dw    <= '0;
      ent_be_n  <= '1;
      ent_wr    <= 1'b0;
      ent_io    <= 1'b0;
      ent_w16   <= 1'b0;
      ent_wdata <= '0;
      pend      <= '0;
      cur_idx   <= '0;
      start_r   <= 1'b0;
    end else begin
      trdy    <= 1'b0;
      stop    <= 1'b0;
      start_r <= 1'b0;

      // PCI side: accept, complete or retry
      if (accept_new) begin
        ent_v     <= 1'b1;
        ent_done  <= 1'b0;
        ent_dw    <= req_dw_addr;
        ent_be_n  <= req_be_n;
        ent_wr    <= req_write;
        ent_io    <= req_io;
        ent_w16   <= port16;
        ent_wdata <= req_wdata;
        pend      <= unit_mask(req_be_n, port16);
        stop      <= delay_en;
      end else if (req_valid && resp_ok) begin
        if (ent_done && match) begin
          trdy  <= 1'b1;
          rdata <= hold;
          ent_v <= 1'b0;
        end else if (delay_en) begin
          stop <= 1'b1;
        end
      end

      // ISA side: launch the next pending unit, or mark the entry done
      if (ent_v && !ent_done && !seq_busy && !start_r) begin
        if (nx_any) begin
          start_r      <= 1'b1;
          cur_idx      <= nx_idx;
          pend[nx_idx] <= 1'b0;
        end else begin
          ent_done <= 1'b1;
        end
      end
    end
  end

  pisa_isa_seq #(.AW(AW), .STROBE_W(STROBE_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .isa_ce   (isa_ce),
    .start    (start_r),
    .s_addr   (sub_addr),
    .s_write  (ent_wr),
    .s_io     (ent_io),
    .s_wdata  (sub_wdata),
    .sd_in    (sd_in),
    .busy     (seq_busy),
    .bale     (bale),
    .sa       (sa),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .memr_n   (memr_n),
    .memw_n   (memw_n),
    .sd_out   (sd_out),
    .sd_oe    (sd_oe),
    .cap_en   (cap_en),
    .cap_data (cap_data)
  );

  pisa_gather #(.LANES(LANES), .DW(DW)) u_gather (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept_new),
    .cap_en   (cap_en),
    .cap_idx  (2'(cur_idx)),
    .cap_w16  (ent_w16),
    .cap_be_n (ent_be_n),
    .cap_data (cap_data),
    .hold     (hold)
  );

  AST_TRDY_AFTER_STROBES: assert property (@(posedge clk) disable iff (rst)
    trdy |-> (ior_n && iow_n && memr_n && memw_n && !bale)); // R9

  AST_STOP_ONLY_DELAYED: assert property (@(posedge clk) disable iff (rst)
    stop |-> $past(delay_en)); // R9

  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(trdy && stop)); // R13

  AST_TRDY_PULSE: assert property (@(posedge clk) disable iff (rst)
    trdy |=> !trdy); // R13

  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (rst)
    stop |=> !stop); // R13

endmodule

// File: tb/test_pisa_bridge.sv
module test_pisa_bridge;

  localparam int AW       = 24;
  localparam int STROBE_W = 3;
  localparam int DIV      = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          isa_ce = 1'b0;
  logic          delay_en = 1'b0;
  logic          port16 = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_io = 1'b0;
  logic [AW-3:0] req_dw_addr = '0;
  logic [3:0]    req_be_n = 4'hF;
  logic [31:0]   req_wdata = '0;
  logic          trdy, stop, bale, ior_n, iow_n, memr_n, memw_n, sd_oe;
  logic [31:0]   rdata;
  logic [AW-1:0] sa;
  logic [15:0]   sd_out, sd_in;

  always #2 clk = ~clk;

  pisa_bridge #(.AW(AW), .STROBE_W(STROBE_W)) i_pisa_bridge (
    .clk(clk), .rst(rst), .isa_ce(isa_ce), .delay_en(delay_en), .port16(port16),
    .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
    .req_dw_addr(req_dw_addr), .req_be_n(req_be_n), .req_wdata(req_wdata),
    .trdy(trdy), .stop(stop), .rdata(rdata), .bale(bale), .sa(sa),
    .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
    .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
  );

  function automatic logic [7:0] dev_byte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // Device model: low byte at sa, high byte at the odd address of the word
  assign sd_in = {dev_byte({sa[AW-1:1], 1'b1}), dev_byte(sa)};

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ISA clock enable: one fast cycle in DIV
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      isa_ce = (c % DIV == 0);
    end
  end

  // ISA bus monitor
  int            sub_n = 0;
  logic [AW-1:0] sub_sa   [8];
  logic [1:0]    sub_kind [8];
  logic [15:0]   sub_dat  [8];
  logic          sub_oe   [8];
  bit            have_rise = 0;
  int            cyc = 0, rise_cyc = 0, bale_cnt = 0, low_cnt = 0;
  logic          prev_bale = 0, prev_low = 0;
  logic [AW-1:0] cur_sa;
  logic [1:0]    cur_kind;
  logic [15:0]   cur_dat;
  logic          cur_oe;

  always @(negedge clk) begin
    logic low;
    cyc++;
    low = !(ior_n && iow_n && memr_n && memw_n);
    if (!rst) begin
      if (bale) bale_cnt++;
      if (bale && !prev_bale) begin
        cur_sa = sa;
        if (have_rise) chk("R6 idle gap", 64'(cyc - rise_cyc), 64'(DIV));
      end
      if (prev_bale && !bale) begin
        chk("R5 bale width", 64'(bale_cnt), 64'(DIV));
        chk("R5 strobe follows bale", 64'(low), 64'd1);
        bale_cnt = 0;
      end
      if (low) begin
        low_cnt++;
        cur_kind = !ior_n ? 2'd0 : !iow_n ? 2'd1 : !memr_n ? 2'd2 : 2'd3;
        cur_dat  = sd_out;
        cur_oe   = sd_oe;
      end
      if (prev_low && !low) begin
        chk("R5 strobe width", 64'(low_cnt), 64'(STROBE_W * DIV));
        if (sub_n < 8) begin
          sub_sa[sub_n]   = cur_sa;
          sub_kind[sub_n] = cur_kind;
          sub_dat[sub_n]  = cur_dat;
          sub_oe[sub_n]   = cur_oe;
        end
        sub_n++;
        low_cnt   = 0;
        rise_cyc  = cyc;
        have_rise = 1;
      end
    end
    prev_bale = bale;
    prev_low  = low;
  end

  // Expected sub-cycles
  int            exp_n;
  logic [AW-1:0] exp_sa   [4];
  logic [15:0]   exp_dat  [4];
  logic [31:0]   exp_rdata;

  task automatic build_exp(input logic [AW-3:0] dw, input logic [3:0] be_n,
                           input logic [31:0] wd, input logic w16);
    logic [AW-1:0] base;
    base = {dw, 2'b00};
    exp_n = 0;
    exp_rdata = '0;
    for (int i = 0; i < 4; i++)
      if (!be_n[i]) exp_rdata[8*i +: 8] = dev_byte(base + AW'(i));
    if (w16) begin
      for (int j = 0; j < 2; j++) begin
        if (!(be_n[2*j] && be_n[2*j+1])) begin
          exp_sa[exp_n]  = base + AW'(2 * j);
          exp_dat[exp_n] = wd[16*j +: 16];
          exp_n++;
        end
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (!be_n[i]) begin
          exp_sa[exp_n]  = base + AW'(i);
          exp_dat[exp_n] = {8'h00, wd[8*i +: 8]};
          exp_n++;
        end
      end
    end
  endtask

  // One bus attempt; resp: 1 = trdy, 2 = stop, 0 = timeout
  int          resp;
  logic [31:0] got_rdata;
  int          subs_at_resp;

  task automatic attempt(input logic [AW-3:0] dw, input logic [3:0] be_n,
                         input logic wr, input logic io, input logic [31:0] wd);
    int t;
    @(negedge clk);
    req_valid = 1; req_dw_addr = dw; req_be_n = be_n;
    req_write = wr; req_io = io; req_wdata = wd;
    resp = 0;
    t = 0;
    while (resp == 0 && t < 2000) begin
      @(negedge clk);
      t++;
      if (trdy && stop) resp = 3;
      else if (trdy) resp = 1;
      else if (stop) resp = 2;
    end
    got_rdata    = rdata;
    subs_at_resp = sub_n;
    req_valid    = 0;
    if (resp == 0) chk("R9 response timeout", 64'd0, 64'd1);
  endtask

  task automatic cmp_subs(input logic wr, input logic io, input string rq);
    logic [1:0] kind;
    kind = io ? (wr ? 2'd1 : 2'd0) : (wr ? 2'd3 : 2'd2);
    chk({rq, " sub-cycle count"}, 64'(sub_n), 64'(exp_n));
    for (int k = 0; k < exp_n && k < sub_n; k++) begin
      chk({rq, " address"}, 64'(sub_sa[k]), 64'(exp_sa[k]));
      chk("R4 strobe kind", 64'(sub_kind[k]), 64'(kind));
      chk("R8 data enable", 64'(sub_oe[k]), 64'(wr));
      if (wr) chk("R8 write data", 64'(sub_dat[k]), 64'(exp_dat[k]));
    end
  endtask

  task automatic txn(input logic [AW-3:0] dw, input logic [3:0] be_n, input logic wr,
                     input logic io, input logic w16, input logic [31:0] wd,
                     input logic dly, input logic mism);
    string rq;
    rq = w16 ? "R3" : "R2";
    build_exp(dw, be_n, wd, w16);
    @(negedge clk);
    port16 = w16; delay_en = dly;
    sub_n = 0; have_rise = 0;
    if (!dly) begin
      attempt(dw, be_n, wr, io, wd);
      chk("R9 trdy without stop", 64'(resp), 64'd1);
      chk("R9 all strobes done at trdy", 64'(subs_at_resp), 64'(exp_n));
      if (be_n == 4'hF) chk("R10 no ISA cycle", 64'(sub_n), 64'd0);
      if (!wr) chk("R7 read data", 64'(got_rdata), 64'(exp_rdata));
    end else begin
      int tries;
      attempt(dw, be_n, wr, io, wd);
      chk("R11 first attempt retried", 64'(resp), 64'd2);
      if (mism) begin
        attempt(dw ^ 22'h1, be_n, wr, io, wd);
        chk("R12 mismatch retried", 64'(resp), 64'd2);
        attempt(dw, be_n ^ 4'h1, wr, io, wd);
        chk("R12 mismatch retried", 64'(resp), 64'd2);
      end
      tries = 0;
      resp  = 2;
      while (resp == 2 && tries < 60) begin
        repeat (15) @(negedge clk);
        attempt(dw, be_n, wr, io, wd);
        tries++;
      end
      chk("R12 matching retry completes", 64'(resp), 64'd1);
      chk("R11 background sub-cycles", 64'(subs_at_resp), 64'(exp_n));
      if (!wr) chk("R7 delayed read data", 64'(got_rdata), 64'(exp_rdata));
    end
    repeat (3) @(negedge clk);
    cmp_subs(wr, io, rq);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset outputs",
        64'({trdy, stop, bale, sd_oe, ior_n, iow_n, memr_n, memw_n}), 64'b0000_1111);

    // Directed corner cases
    txn(22'h012345, 4'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);         // R2 full read 8-bit
    txn(22'h0ABCDE, 4'h0, 1'b1, 1'b1, 1'b1, 32'hCAFE_F00D, 1'b0, 1'b0); // R3 full write 16-bit
    txn(22'h3FFFFF, 4'hF, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);         // R10 no lanes
    txn(22'h001111, 4'hF, 1'b1, 1'b0, 1'b1, 32'h1, 1'b0, 1'b0);         // R10 no lanes, write
    txn(22'h022222, 4'b1101, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);      // R3 one byte of word 0
    txn(22'h033333, 4'b0111, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);      // R2 lane 3 only
    txn(22'h044444, 4'b1010, 1'b1, 1'b0, 1'b0, 32'h1122_3344, 1'b0, 1'b0); // R8 sparse write
    txn(22'h055555, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0, 1'b1, 1'b1);         // R12 mismatch while pending
    txn(22'h055555, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0, 1'b1, 1'b0);         // R12 entry cleared, fresh stop
    txn(22'h066666, 4'b0011, 1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b1, 1'b1); // R11 delayed write

    // Constrained random mix
    for (int n = 0; n < 40; n++) begin
      logic [AW-3:0] dw;
      logic [3:0]    be;
      logic [31:0]   wd;
      logic          wr, io, w16, dly, mm;
      dw  = 22'($urandom);
      be  = 4'($urandom);
      wd  = $urandom;
      wr  = 1'($urandom);
      io  = 1'($urandom);
      w16 = 1'($urandom);
      dly = ($urandom % 3 == 0);
      mm  = dly && 1'($urandom);
      if (dly && be == 4'hF) be = 4'hE;
      txn(dw, be, wr, io, w16, wd, dly, mm);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule